// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block keeps the status byte of a serial flash target and rules on every request to overwrite it. A request carries a full byte, but only three bits of it can be stored: a lock-down bit and a two-bit block-protection field. Whether a request may take effect depends on the stored lock-down bit, on the active-low write-protect pin and on whether a program or erase is running. The lock-down bit only matters while the pin is low. With the pin high, the lock is ignored.

The command decoder presents a one-cycle request together with its data byte. One cycle later the block answers with a one-cycle accept pulse or a one-cycle reject pulse. The register is updated at the same clock edge as the decision. The two low bits of the status byte report the busy and write-enable inputs directly, so a status read always shows their present values. The write-protect pin comes from a pad and passes through a synchroniser before it is used.

The ruling is made by a three-state machine. `ST_IDLE` means no request arrived at the last edge. `ST_GRANT` means the last request was taken, and it drives `accept_o`. `ST_DENY` means the last request was refused, and it drives `reject_o`. From any state, the next state is `ST_GRANT` on a permitted request, `ST_DENY` on a refused request, and `ST_IDLE` when there is no request. Back-to-back requests therefore give back-to-back answers.

Top module: `sr_guard`

## Requirements
- R1: After reset the lock-down bit (status bit 7) is 0, both block-protection bits (status bits 3:2) are 1, and `accept_o` and `reject_o` are low.
- R2: A request made while the synchronised pin is low and the stored lock-down bit is 1 is refused, and bits 7 and 3:2 keep their values.
- R3: A request made while busy is low, the synchronised pin is low and the lock-down bit is 0 is accepted. Bit 7 then takes data bit 7 and bits 3:2 take data bits 3:2.
- R4: A request made while busy is low and the synchronised pin is high is accepted and stored, whatever the lock-down bit holds.
- R5: Data bits 6:4 and 1:0 are never stored. Status bits 6:4 always read 0, bit 1 reads the write-enable input and bit 0 reads the busy input, all in the same cycle as the inputs.
- R6: A request made while busy is high is refused whatever the pin and lock levels are, and the stored bits are unchanged.
- R7: The decision appears as exactly one pulse on `accept_o` or `reject_o`, one cycle long, in the cycle after the clock edge at which the request was sampled. Neither output is high in a cycle that follows an edge with no request.
- R8: A change on the write-protect pin first affects a decision at the third rising edge after the change. Requests sampled at the first two edges still use the previous level.
- R9: Without an accepted request, bits 7 and 3:2 never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_pin_n | input | 1 | Write-protect pad level, asynchronous; low enables the lock-down |
| wsr_req | input | 1 | One-cycle request to overwrite the status byte |
| wsr_data | input | 8 | Byte carried by the request |
| busy_in | input | 1 | Program or erase in progress; reported as status bit 0 |
| wel_in | input | 1 | Write-enable latch level; reported as status bit 1 |
| status_o | output | 8 | Current status byte |
| accept_o | output | 1 | Pulses for one cycle after a request that took effect |
| reject_o | output | 1 | Pulses for one cycle after a refused request |

## Verification
A wrong stored lock-down bit does not show up until the next request made while the pin is low. At that point the answer pulse is on the wrong output one cycle after the request, and the stored fields update when they should not, or stay put when they should update. A stale synchroniser stage shows only in the two cycles after a pin change, so the bench makes requests at exactly those edges. A state-machine fault shows as a missing pulse, a doubled pulse or a stretched pulse in the cycle after a request.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    // Bit positions inside the status byte
    localparam int SR_W     = 8;
    localparam int LOCK_POS = 7;
    localparam int BP_LO    = 2;
    localparam int BP_W     = 2;
    localparam int WEL_POS  = 1;
    localparam int BUSY_POS = 0;
    localparam int PAD_W    = LOCK_POS - (BP_LO + BP_W);

    // Reset pattern of the protection field: all blocks protected
    localparam logic [BP_W-1:0] BP_RESET = {BP_W{1'b1}};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } wsr_state_e;

    typedef struct packed {
        logic            lock;
        logic [BP_W-1:0] bp;
    } sr_fields_t;

endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/sr_perm.sv
module sr_perm (
    input  logic req,
    input  logic busy,
    input  logic wp_high,
    input  logic lock,
    output logic grant,
    output logic deny
);
    logic lock_active;

    always_comb begin
        // The lock-down bit only bites while the pin is low
        lock_active = lock && !wp_high;
        grant = 1'b0;
        deny  = 1'b0;
        if (req) begin
            if (busy || lock_active) deny  = 1'b1;
            else                     grant = 1'b1;
        end
    end

endmodule

// File: rtl/sr_reg.sv
module sr_reg
    import sr_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  sr_fields_t wfields,
    output sr_fields_t fields
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields.lock <= 1'b0;
            fields.bp   <= BP_RESET;
        end else if (we) begin
            fields <= wfields;
        end
    end

    // R9: stored fields move only on a write
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(fields));

    // R3: a write lands exactly as presented
    p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> fields == $past(wfields));

endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wp_pin_n,
    input  logic        wsr_req,
    input  logic [7:0]  wsr_data,
    input  logic        busy_in,
    input  logic        wel_in,
    output logic [7:0]  status_o,
    output logic        accept_o,
    output logic        reject_o
);
    wsr_state_e state_q, state_d;
    logic       wp_high;
    logic       grant, deny;
    sr_fields_t cur_fields, new_fields;

    wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wp_pin_n),
        .sync_out (wp_high)
    );

    sr_perm u_perm (
        .req     (wsr_req),
        .busy    (busy_in),
        .wp_high (wp_high),
        .lock    (cur_fields.lock),
        .grant   (grant),
        .deny    (deny)
    );

    always_comb begin
        new_fields.lock = wsr_data[LOCK_POS];
        new_fields.bp   = wsr_data[BP_LO +: BP_W];
    end

    sr_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (grant),
        .wfields (new_fields),
        .fields  (cur_fields)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: every state follows the same request ruling
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_DENY: begin
                if (grant)     state_d = ST_GRANT;
                else if (deny) state_d = ST_DENY;
                else           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept_o = 1'b0;
        reject_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_GRANT: accept_o = 1'b1;
            ST_DENY:  reject_o = 1'b1;
            default:  ;
        endcase
        status_o                    = '0;
        status_o[LOCK_POS]          = cur_fields.lock;
        status_o[BP_LO +: BP_W]     = cur_fields.bp;
        status_o[WEL_POS]           = wel_in;
        status_o[BUSY_POS]          = busy_in;
    end

    // R2: locked with pin low refuses and keeps the fields
    p_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wsr_req && !wp_high && cur_fields.lock |=> reject_o && $stable(cur_fields));

    // R3: unlocked, idle engine, pin low accepts
    p_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wsr_req && !busy_in && !wp_high && !cur_fields.lock |=> accept_o);

    // R4: pin high disables the lock
    p_pin_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wsr_req && !busy_in && wp_high |=> accept_o);

    // R5: unstored data bits never reach the status byte
    p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wsr_req && (wsr_data[6:4] != 3'b000) |=> status_o[6:4] == 3'b000);
    p_ro_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wsr_req && (wsr_data[1:0] != {wel_in, busy_in}) |=> status_o[1:0] == {wel_in, busy_in});

    // R6: busy refuses
    p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wsr_req && busy_in |=> reject_o && $stable(cur_fields));

    // R7: one answer per request, none without one
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept_o, reject_o}));
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wsr_req |=> !accept_o && !reject_o);
    p_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wsr_req |=> accept_o || reject_o);

endmodule

// File: tb/sr_guard_test.sv
module sr_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_pin_n = 1'b1;
    logic       wsr_req = 1'b0;
    logic [7:0] wsr_data = 8'h00;
    logic       busy_in = 1'b0;
    logic       wel_in = 1'b0;
    logic [7:0] status_o;
    logic       accept_o, reject_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the stored fields
    logic       m_lock;
    logic [1:0] m_bp;

    always #5 clk = ~clk;

    sr_guard uut (
        .clk(clk), .rst_n(rst_n), .wp_pin_n(wp_pin_n), .wsr_req(wsr_req),
        .wsr_data(wsr_data), .busy_in(busy_in), .wel_in(wel_in),
        .status_o(status_o), .accept_o(accept_o), .reject_o(reject_o)
    );

    function automatic logic [7:0] exp_status(logic lk, logic [1:0] bp, logic wel, logic bsy);
        return {lk, 3'b000, bp, wel, bsy};
    endfunction

    function automatic logic permitted(logic bsy, logic pin, logic lk);
        return !bsy && (pin || !lk);
    endfunction

    task automatic check(string rq, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Called at a negedge; drives one request and samples one cycle on
    task automatic request(string rq, logic [7:0] d, logic bsy, logic wel, logic pin_seen);
        logic p;
        p = permitted(bsy, pin_seen, m_lock);
        wsr_req = 1'b1; wsr_data = d; busy_in = bsy; wel_in = wel;
        @(posedge clk);
        @(negedge clk);
        wsr_req = 1'b0;
        if (p) begin
            m_lock = d[7];
            m_bp   = d[3:2];
        end
        check({rq, " answer"}, {6'b0, accept_o, reject_o}, {6'b0, p, !p});
        check({rq, " status"}, status_o, exp_status(m_lock, m_bp, wel, bsy));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            wsr_req = 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        m_lock = 1'b0;
        m_bp   = 2'b11;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 status", status_o, 8'h0C);
        check("R1 pulses", {6'b0, accept_o, reject_o}, 8'h00);
        idle(3);

        // R3 unlock path with pin low
        wp_pin_n = 1'b0;
        idle(3);
        request("R3 open write", 8'h84, 1'b0, 1'b1, 1'b0);
        // R7 no answer when no request follows
        idle(1);
        check("R7 quiet", {6'b0, accept_o, reject_o}, 8'h00);
        // R2 now locked, pin low; R5 data pad bits ignored
        request("R2 locked write", 8'h7B, 1'b0, 1'b0, 1'b0);
        // R9 fields unchanged after refused request
        idle(2);
        check("R9 hold", status_o, exp_status(m_lock, m_bp, 1'b0, 1'b0));
        // R6 busy refuses even with pin high
        wp_pin_n = 1'b1;
        idle(3);
        request("R6 busy write", 8'h00, 1'b1, 1'b0, 1'b1);
        // R4 pin high overrides lock; R5 pad bits dropped
        request("R4 pin high write", 8'hF0, 1'b0, 1'b1, 1'b1);
        check("R5 pad bits", status_o & 8'h70, 8'h00);
        // R7 back-to-back requests give back-to-back answers
        request("R7 back to back", 8'h8C, 1'b0, 1'b0, 1'b1);

        // R8 synchroniser latency: lock=1, pin goes low
        wp_pin_n = 1'b0;
        idle(1);
        request("R8 second edge old level", 8'h88, 1'b0, 1'b0, 1'b1);
        request("R8 third edge new level", 8'h00, 1'b0, 1'b0, 1'b0);
        idle(2);

        // Random phase: R2 R3 R4 R5 R6
        for (int it = 0; it < 400; it++) begin
            logic [7:0] d;
            logic bsy, wel;
            if ($urandom_range(0, 7) == 0) begin
                wp_pin_n = $urandom_range(0, 1);
                idle(3);
            end
            d   = 8'($urandom);
            bsy = ($urandom_range(0, 3) == 0);
            wel = $urandom_range(0, 1);
            if ($urandom_range(0, 4) == 0) begin
                busy_in = bsy; wel_in = wel;
                idle(1);
                check("R9 random idle", status_o, exp_status(m_lock, m_bp, wel, bsy));
            end else begin
                request("R2/R3/R4/R6 random", d, bsy, wel, wp_pin_n);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule